// File: doc/BRIEF.md
# Nested Interrupt Controller

This block arbitrates hardware interrupt sources and software exceptions for a processor core. Each source has a pending bit, an enable bit and a programmable vector word. The block picks one winner and gives the core a one-cycle take pulse, the winner's vector and index, and a flag that says whether the pipeline must be flushed. A software exception is taken at once, whatever the enables and the service state, and the flush flag is raised with it. A hardware interrupt never raises the flush flag, so work already in the pipeline completes.

A one-hot active-service vector records which sources are in service. In nested mode a new source may enter only when its priority is above every source in service. In non-nested mode nothing enters until the vector is empty again. A return pulse from the core clears the highest-priority bit in service. Four consecutive request lines, starting at index `EXT_BASE`, can each be set to edge or level sensitivity at run time. Every other source has its sensitivity fixed by the `FIXED_EDGE` parameter.

Top module: `nestIrqCtrl`

## Requirements
- R1: After reset, `takeReq`, `abortPipe` and `activeStack` are 0. All enable bits are 0, so a request raised before any enable is written is never taken. All four programmable lines start as level sensitive.
- R2: Enable bit i (a 1 in `maskData` bit i) is required before source i can be taken. A disabled pending source is skipped in favour of an enabled one.
- R3: Among eligible pending sources, the lowest index wins.
- R4: With a take, `takeSrc` holds the winner's index and `takeVec` holds the vector word last written at that index. Vector slot `NUM_SRC` belongs to the software exception.
- R5: When `nestEn` is 1, a source is eligible only if its index is below every index set in `activeStack`. A take sets bit `takeSrc` of `activeStack`.
- R6: When `nestEn` is 0, no hardware source is taken while `activeStack` is non-zero.
- R7: An edge-sensitive source latches a 0-to-1 change of its input, even while it is disabled. The take clears the latch, so one pulse gives exactly one take.
- R8: A level-sensitive source is pending only while its input is high. A level request that drops while disabled is lost. A request still high after its return is taken again.
- R9: Bit j of `senseData`, written with `senseWe`, selects edge (1) or level (0) for source `EXT_BASE`+j. Every other source has the sensitivity given by bit i of `FIXED_EDGE`.
- R10: A pulse on `excReq` gives `takeReq`=1 and `abortPipe`=1 at the next rising edge, with the vector from slot `NUM_SRC`. This ignores enables and `activeStack` and leaves `activeStack` unchanged. A hardware take due in that cycle waits one cycle.
- R11: Every hardware take has `abortPipe`=0.
- R12: A `rtiIn` pulse clears the lowest-index set bit of `activeStack`. It does nothing when `activeStack` is 0.
- R13: A hardware request whose input rises before clock edge A is latched at edge A. It appears on `takeReq` at edge A+1, and `takeReq` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Hardware request lines, index 0 highest priority |
| nestEn | input | 1 | 1 = nested servicing, 0 = non-nested |
| excReq | input | 1 | Software exception pulse |
| rtiIn | input | 1 | Return-from-interrupt pulse |
| maskWe | input | 1 | Write strobe for the enable register |
| maskData | input | NUM_SRC | New enable bits, 1 = enabled |
| senseWe | input | 1 | Write strobe for the sensitivity of the programmable lines |
| senseData | input | 4 | 1 = edge, 0 = level, for lines EXT_BASE..EXT_BASE+3 |
| vecWe | input | 1 | Vector write strobe |
| vecIdx | input | IDX_W | Vector slot, 0..NUM_SRC |
| vecData | input | VEC_W | Vector word |
| takeReq | output | 1 | One-cycle take pulse |
| abortPipe | output | 1 | Flush the pipeline (exception take) |
| takeVec | output | VEC_W | Vector of the taken source |
| takeSrc | output | IDX_W | Index of the taken source (0 on exception) |
| activeStack | output | NUM_SRC | One-hot set of sources in service |

## Verification
The bound checker watches the service-state rules on every cycle:
- In nested mode, a hardware take is always of higher priority than everything in service.
- In non-nested mode, nothing is taken unless the service set was empty.
- A take always marks its own bit.
- A return removes exactly one bit.
- Exceptions always flush and never touch the service set.

Only the bench's scenarios can show the rest:
- Which source wins.
- That the vector words are right.
- The latching differences between edge and level sources, including pulses lost or held while disabled.
- The sensitivity switch on the programmable lines.
- The one-cycle delay of a hardware take behind a coincident exception.

// File: rtl/nestIrqPkg.sv
package nestIrqPkg;
  // Strobes from control to datapath for one arbitration cycle
  typedef struct packed {
    logic takeHw;   // hardware winner accepted this cycle
    logic takeExc;  // software exception accepted this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/icDatapath.sv
module icDatapath
  import nestIrqPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W = 32,
  parameter int EXT_BASE = 8,
  parameter logic [NUM_SRC-1:0] FIXED_EDGE = '0,
  parameter int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskData,
  input  logic               senseWe,
  input  logic [3:0]         senseData,
  input  logic               vecWe,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic [VEC_W-1:0]   vecData,
  input  logic [NUM_SRC-1:0] allowMask,
  input  ctlStrobe_t         strobe,
  output logic               candValid,
  output logic [NUM_SRC-1:0] candHot,
  output logic [VEC_W-1:0]   takeVec,
  output logic [IDX_W-1:0]   takeSrc
);
  localparam int NUM_VEC = NUM_SRC + 1;
  localparam int EXC_SLOT = NUM_SRC;

  logic [NUM_SRC-1:0] latchReg, maskReg, prevIrq, edgeSel, pend, clrHot, latchNext;
  logic [3:0]         senseReg;
  logic [IDX_W-1:0]   candIdx;
  logic [VEC_W-1:0]   vecTab [NUM_VEC];

  // Sensitivity per source: programmable window or fixed parameter bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSense
    if (i >= EXT_BASE && i < EXT_BASE + 4) begin : gProg
      assign edgeSel[i] = senseReg[i - EXT_BASE];
    end else begin : gFixed
      assign edgeSel[i] = FIXED_EDGE[i];
    end
  end

  assign clrHot    = strobe.takeHw ? candHot : '0;
  assign latchNext = (edgeSel & ((latchReg & ~clrHot) | (irqIn & ~prevIrq)))
                   | (~edgeSel & irqIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      prevIrq  <= '0;
      maskReg  <= '0;
      senseReg <= '0;
    end else begin
      latchReg <= latchNext;
      prevIrq  <= irqIn;
      if (maskWe)  maskReg  <= maskData;
      if (senseWe) senseReg <= senseData;
    end
  end

  // Candidate: lowest-index pending, enabled and allowed source
  assign pend      = latchReg & maskReg & allowMask;
  assign candHot   = pend & (~pend + NUM_SRC'(1));
  assign candValid = |pend;

  always_comb begin
    candIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) candIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_VEC; k++) vecTab[k] <= '0;
      takeVec <= '0;
      takeSrc <= '0;
    end else begin
      if (vecWe && vecIdx <= IDX_W'(EXC_SLOT)) vecTab[vecIdx] <= vecData;
      if (strobe.takeExc) begin
        takeVec <= vecTab[EXC_SLOT];
        takeSrc <= '0;
      end else if (strobe.takeHw) begin
        takeVec <= vecTab[candIdx];
        takeSrc <= candIdx;
      end
    end
  end
endmodule

// File: rtl/icControl.sv
module icControl
  import nestIrqPkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nestEn,
  input  logic               excReq,
  input  logic               rtiIn,
  input  logic               candValid,
  input  logic [NUM_SRC-1:0] candHot,
  output ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] allowMask,
  output logic               takeReq,
  output logic               abortPipe,
  output logic [NUM_SRC-1:0] activeStack
);
  logic [NUM_SRC-1:0] lowAct, popHot, pushHot;

  // Highest-priority entry in service
  assign lowAct = activeStack & (~activeStack + NUM_SRC'(1));

  // Nested: only indices below lowAct (all when idle). Non-nested: only when idle.
  assign allowMask = nestEn ? (lowAct - NUM_SRC'(1))
                            : ((activeStack == '0) ? '1 : '0);

  assign strobe.takeExc = excReq;
  assign strobe.takeHw  = candValid & ~excReq;

  assign popHot  = rtiIn ? lowAct : '0;
  assign pushHot = strobe.takeHw ? candHot : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeStack <= '0;
      takeReq     <= 1'b0;
      abortPipe   <= 1'b0;
    end else begin
      activeStack <= (activeStack & ~popHot) | pushHot;
      takeReq     <= strobe.takeExc | strobe.takeHw;
      abortPipe   <= strobe.takeExc;
    end
  end
endmodule

// File: rtl/nestIrqCtrl.sv
module nestIrqCtrl
  import nestIrqPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W = 32,
  parameter int EXT_BASE = 8,
  parameter logic [NUM_SRC-1:0] FIXED_EDGE = 16'hC000,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               nestEn,
  input  logic               excReq,
  input  logic               rtiIn,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskData,
  input  logic               senseWe,
  input  logic [3:0]         senseData,
  input  logic               vecWe,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic [VEC_W-1:0]   vecData,
  output logic               takeReq,
  output logic               abortPipe,
  output logic [VEC_W-1:0]   takeVec,
  output logic [IDX_W-1:0]   takeSrc,
  output logic [NUM_SRC-1:0] activeStack
);
  ctlStrobe_t         strobe;
  logic               candValid;
  logic [NUM_SRC-1:0] candHot, allowMask;

  icDatapath #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .EXT_BASE(EXT_BASE),
    .FIXED_EDGE(FIXED_EDGE), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .maskWe(maskWe), .maskData(maskData),
    .senseWe(senseWe), .senseData(senseData),
    .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData),
    .allowMask(allowMask), .strobe(strobe),
    .candValid(candValid), .candHot(candHot),
    .takeVec(takeVec), .takeSrc(takeSrc)
  );

  icControl #(.NUM_SRC(NUM_SRC)) uCtl (
    .clk(clk), .rstN(rstN), .nestEn(nestEn), .excReq(excReq), .rtiIn(rtiIn),
    .candValid(candValid), .candHot(candHot),
    .strobe(strobe), .allowMask(allowMask),
    .takeReq(takeReq), .abortPipe(abortPipe), .activeStack(activeStack)
  );
endmodule

// File: rtl/nestIrqChk.sv
module nestIrqChk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               nestEn,
  input logic               excReq,
  input logic               rtiIn,
  input logic               takeReq,
  input logic               abortPipe,
  input logic [IDX_W-1:0]   takeSrc,
  input logic [NUM_SRC-1:0] activeStack
);
  logic             pastOk;
  logic [IDX_W-1:0] lowNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  always_comb begin
    lowNow = IDX_W'(NUM_SRC);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeStack[i]) lowNow = IDX_W'(i);
    end
  end

  AST_NEST_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && takeReq && !abortPipe && $past(nestEn) |-> takeSrc < $past(lowNow)); // R5
  AST_PUSH_OWN_BIT: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && !abortPipe |-> activeStack[takeSrc]); // R5
  AST_FLAT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && takeReq && !abortPipe && !$past(nestEn) |-> $past(activeStack) == '0); // R6
  AST_EXC_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> takeReq && abortPipe); // R10
  AST_EXC_STACK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && abortPipe && !$past(rtiIn) |-> activeStack == $past(activeStack)); // R10
  AST_HW_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && abortPipe |-> $past(excReq)); // R11
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(rtiIn) && !(takeReq && !abortPipe) |->
      $countones(activeStack) ==
      $countones($past(activeStack)) - (($past(activeStack) != '0) ? 1 : 0)); // R12
endmodule

bind nestIrqCtrl nestIrqChk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .nestEn(nestEn), .excReq(excReq), .rtiIn(rtiIn),
  .takeReq(takeReq), .abortPipe(abortPipe), .takeSrc(takeSrc),
  .activeStack(activeStack)
);

// File: tb/sim_nestIrqCtrl.sv
`timescale 1ns/1ps
module sim_nestIrqCtrl;
  localparam int NS = 16;
  localparam int VW = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] irqIn = '0;
  logic nestEn = 1'b1, excReq = 1'b0, rtiIn = 1'b0;
  logic maskWe = 1'b0, senseWe = 1'b0, vecWe = 1'b0;
  logic [NS-1:0] maskData = '0;
  logic [3:0] senseData = '0;
  logic [IW-1:0] vecIdx = '0;
  logic [VW-1:0] vecData = '0;
  logic takeReq, abortPipe;
  logic [VW-1:0] takeVec;
  logic [IW-1:0] takeSrc;
  logic [NS-1:0] activeStack;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  nestIrqCtrl u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .nestEn(nestEn), .excReq(excReq),
    .rtiIn(rtiIn), .maskWe(maskWe), .maskData(maskData), .senseWe(senseWe),
    .senseData(senseData), .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData),
    .takeReq(takeReq), .abortPipe(abortPipe), .takeVec(takeVec),
    .takeSrc(takeSrc), .activeStack(activeStack)
  );

  // {request pattern, enables, expect take, expected index}
  localparam logic [37:0] VTBL [0:7] = '{
    {16'h0010, 16'hFFFF, 1'b1, 5'd4},
    {16'h0801, 16'hFFFF, 1'b1, 5'd0},
    {16'h0A00, 16'hFFFF, 1'b1, 5'd9},
    {16'h00F0, 16'h00E0, 1'b1, 5'd5},
    {16'h0003, 16'h0000, 1'b0, 5'd0},
    {16'h8000, 16'h8000, 1'b1, 5'd15},
    {16'h0000, 16'hFFFF, 1'b0, 5'd0},
    {16'h3FFF, 16'hFFFE, 1'b1, 5'd1}
  };

  function automatic logic [VW-1:0] expVec(input int i);
    return (i == NS) ? 32'h0000_E000 : 32'h0000_1000 + 32'(i) * 32'd16;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMask(input logic [NS-1:0] m);
    maskData = m; maskWe = 1'b1; nclk(1); maskWe = 1'b0;
  endtask

  task automatic rti1();
    rtiIn = 1'b1; nclk(1); rtiIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    nclk(2);
    rstN = 1'b1;
    nclk(1);
    chk("R1 takeReq", 32'(takeReq), 0);
    chk("R1 abortPipe", 32'(abortPipe), 0);
    chk("R1 stack", 32'(activeStack), 0);
    irqIn = 16'h0004; nclk(3);
    chk("R1 enables off", 32'(takeReq), 0);
    irqIn = '0; nclk(1);

    for (int i = 0; i <= NS; i++) begin
      vecIdx = IW'(i); vecData = expVec(i); vecWe = 1'b1; nclk(1);
    end
    vecWe = 1'b0;

    // table walk, nested mode
    for (int e = 0; e < 8; e++) begin
      setMask(VTBL[e][21:6]);
      irqIn = VTBL[e][37:22];
      nclk(2);
      chk("R2 take", 32'(takeReq), 32'(VTBL[e][5]));
      if (VTBL[e][5]) begin
        chk("R3 src", 32'(takeSrc), 32'(VTBL[e][4:0]));
        chk("R4 vec", takeVec, expVec(int'(VTBL[e][4:0])));
        chk("R11 abort", 32'(abortPipe), 0);
      end
      irqIn = '0; nclk(1); rti1(); nclk(1);
      chk("R12 stack idle", 32'(activeStack), 0);
    end
    setMask('1);

    // nested preemption
    nestEn = 1'b1;
    irqIn = 16'h0020; nclk(1);
    chk("R13 not yet", 32'(takeReq), 0);
    nclk(1);
    chk("R13 take", 32'(takeReq), 1);
    chk("R5 src5", 32'(takeSrc), 5);
    irqIn = 16'h0024; nclk(2);
    chk("R5 preempt src2", 32'(takeSrc), 2);
    chk("R5 stack", 32'(activeStack), 32'h24);
    irqIn = 16'h00A4; nclk(2);
    chk("R5 lower blocked", 32'(takeReq), 0);
    irqIn = '0; nclk(1); rti1();
    chk("R12 pop lowest", 32'(activeStack), 32'h20);
    rti1();
    chk("R12 pop last", 32'(activeStack), 0);

    // non-nested
    nestEn = 1'b0;
    irqIn = 16'h0020; nclk(2);
    chk("R6 src5", 32'(takeSrc), 5);
    irqIn = 16'h0024; nclk(3);
    chk("R6 no preempt", 32'(takeReq), 0);
    irqIn = 16'h0004; rti1(); nclk(1);
    chk("R6 after return", 32'(takeReq), 1);
    chk("R6 src2", 32'(takeSrc), 2);
    irqIn = '0; nclk(1); rti1();
    chk("R6 idle", 32'(activeStack), 0);
    nestEn = 1'b1;

    // level retake and loss
    irqIn = 16'h0008; nclk(2);
    chk("R8 src3", 32'(takeSrc), 3);
    nclk(1); rti1(); nclk(1);
    chk("R8 retake", 32'(takeReq), 1);
    chk("R8 retake src", 32'(takeSrc), 3);
    irqIn = '0; nclk(1); rti1();
    setMask(16'hFFBF);
    irqIn = 16'h0040; nclk(2); irqIn = '0; nclk(2);
    setMask('1); nclk(2);
    chk("R8 level lost", 32'(takeReq), 0);
    chk("R8 stack", 32'(activeStack), 0);

    // fixed edge source held while disabled
    setMask(16'hBFFF);
    irqIn = 16'h4000; nclk(1); irqIn = '0; nclk(2);
    setMask('1); nclk(1);
    chk("R7 edge held", 32'(takeReq), 1);
    chk("R7 src14", 32'(takeSrc), 14);
    rti1(); nclk(2);
    chk("R7 single take", 32'(takeReq), 0);
    chk("R7 stack", 32'(activeStack), 0);

    // programmable line 9 switched to edge, line 10 stays level
    senseData = 4'b0010; senseWe = 1'b1; nclk(1); senseWe = 1'b0;
    setMask(16'hFDFF);
    irqIn = 16'h0200; nclk(1); irqIn = '0; nclk(2);
    setMask('1); nclk(1);
    chk("R9 prog edge", 32'(takeReq), 1);
    chk("R9 src9", 32'(takeSrc), 9);
    rti1();
    setMask(16'hFBFF);
    irqIn = 16'h0400; nclk(1); irqIn = '0; nclk(2);
    setMask('1); nclk(2);
    chk("R9 prog level", 32'(takeReq), 0);

    // exceptions
    irqIn = 16'h0010; nclk(2);
    chk("R10 hw src4", 32'(takeSrc), 4);
    irqIn = '0;
    setMask('0);
    excReq = 1'b1; nclk(1); excReq = 1'b0;
    chk("R10 exc take", 32'(takeReq), 1);
    chk("R10 exc abort", 32'(abortPipe), 1);
    chk("R10 exc vec", takeVec, expVec(NS));
    chk("R10 stack kept", 32'(activeStack), 32'h10);
    setMask('1); rti1();
    irqIn = 16'h0008; nclk(1);
    excReq = 1'b1; nclk(1); excReq = 1'b0;
    chk("R10 exc first", 32'(abortPipe), 1);
    nclk(1);
    chk("R10 hw after", 32'(takeReq), 1);
    chk("R11 hw no abort", 32'(abortPipe), 0);
    chk("R10 hw src3", 32'(takeSrc), 3);
    irqIn = '0; nclk(1); rti1();
    chk("R12 final", 32'(activeStack), 0);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule